// File: doc/BRIEF.md
# Programmable Serial Flash Sequencer

This block sequences transactions on a serial NOR flash port with one, two or four data lanes. Commands are not fixed in logic. A table holds several short programs, and each entry in a program is a typed instruction with its own lane width and an 8-bit operand. A start request names a program and supplies a flash address. The engine then walks the entries in order. It pulls chip select low, clocks out command, address, mode and write bytes, and idles for dummy cycles. It also gathers read data into bytes and hands each finished byte to a receive queue.

Each serial cycle lasts one `clk` period in which `sck_en` is high. The flash clock is formed from `clk` outside the block, and only in the cycles where `sck_en` is high. Before its serial cycles, each entry takes one setup cycle in which chip select is low and `sck_en` is low.

A jump instruction ends a transaction and also saves a restart point for the same program. A continuous-read program can therefore skip its command byte on later runs. The block raises `busy` for the whole transaction and pulses `done` once at the end.

Top module: `sflash_seq`

## Requirements
- R1: A table entry is 16 bits wide. Bits [15:10] hold the instruction code, bits [9:8] the lane field and bits [7:0] the operand. The codes are: 1 command, 2 address, 3 dummy, 4 mode, 7 read, 8 write, 9 jump. The lane field selects the width: 0 is one lane, 1 is two lanes, 2 is four lanes, and 3 is treated as one lane. While data is driven, `io_oe` is 0001, 0011 or 1111 to match the width. The table is written at index program*8+entry through `tbl_we`.
- R2: After reset, program 0 holds four entries: command 0x03 on one lane, 24 address bits on one lane, read 8 bytes on one lane, then jump to entry 0. Every other table entry is 0.
- R3: When the block is idle, `start` loads the program `start_seq` at its saved restart entry, which is 0 after reset. One cycle later `busy` is high and `cs_n` is low. A `start` that arrives while `busy` is high is ignored and leaves the running transaction unchanged.
- R4: The command and mode instructions each send their 8-bit operand MSB first, taking 8/width serial cycles. On one lane the data goes out on IO0. On two lanes IO1 carries the more significant bit. On four lanes IO3 carries the most significant bit. Lanes that are not driven read 0 on `io_out`.
- R5: The address instruction sends the low N bits of the start address MSB first, where N is the operand limited to 32. It takes ceil(N/width) serial cycles.
- R6: The dummy instruction gives as many serial cycles as its operand, with all lanes released. An address, dummy, read or write instruction whose operand is 0 takes no serial cycle.
- R7: The read instruction clocks in operand×8/width cycles with all lanes released. Bits are shifted in MSB first: from IO1 alone on one lane, IO1:IO0 on two lanes, and IO3:IO0 on four lanes. Each finished byte appears on `rx_data` with `rx_push` high for one cycle.
- R8: The write instruction sends as many bytes as its operand. Each byte is taken from `tx_data` with a single-cycle `tx_pop` and shifted out as in R4.
- R9: The jump instruction ends the transaction and stores the low 3 bits of its operand as the restart entry for the next start of the same program.
- R10: A code that is not listed in R1 ends the transaction. Finishing entry 7 without a jump also ends it. In both cases the restart entry stays as it was.
- R11: At the end of a transaction, `done` is high for exactly one cycle, with `cs_n` already high. `busy` is low in the next cycle. Whenever `cs_n` is high, `sck_en` is low and no lane is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 7 | Table index, program*8+entry |
| tbl_wdata | input | 16 | Table entry to write |
| start | input | 1 | Start request |
| start_seq | input | 4 | Program to run |
| start_addr | input | 32 | Flash address for the transaction |
| tx_data | input | 8 | Next write byte |
| tx_pop | output | 1 | Write byte consumed |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | Received byte valid |
| cs_n | output | 1 | Flash chip select, active low |
| sck_en | output | 1 | Serial clock enable for this cycle |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished pulse |

## Verification
The assertions check, on every cycle, the rules that do not depend on any program:
- the lanes and the clock are quiet while chip select is high;
- only legal lane masks are driven;
- `done` is followed by idle;
- a transaction begins only on a start request;
- receive bytes arrive only right after a clocked cycle with the lanes released;
- write bytes are taken only while chip select is low.

The bit order on each lane, the cycle count of each instruction, the restart point left behind by a jump, and the stop on an unknown code or after the eighth entry can only be shown by running programs. The bench does this: it runs each program and compares the captured lane stream and byte traffic against its own model of the table.

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int SEQS   = 16,
  parameter int STEPS  = 8,
  parameter int ADDR_W = 32
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         tbl_we,
  input  logic [$clog2(SEQS)+$clog2(STEPS)-1:0]        tbl_addr,
  input  logic [15:0]                                  tbl_wdata,
  input  logic                                         start,
  input  logic [$clog2(SEQS)-1:0]                      start_seq,
  input  logic [ADDR_W-1:0]                            start_addr,
  input  logic [7:0]                                   tx_data,
  output logic                                         tx_pop,
  output logic [7:0]                                   rx_data,
  output logic                                         rx_push,
  output logic                                         cs_n,
  output logic                                         sck_en,
  output logic [3:0]                                   io_out,
  output logic [3:0]                                   io_oe,
  input  logic [3:0]                                   io_in,
  output logic                                         busy,
  output logic                                         done
);
  localparam int SEQ_W  = $clog2(SEQS);
  localparam int STEP_W = $clog2(STEPS);
  localparam int TBL    = SEQS * STEPS;

  localparam logic [5:0] OP_CMD = 6'd1, OP_ADDR = 6'd2, OP_DUMMY = 6'd3, OP_MODE = 6'd4,
                         OP_READ = 6'd7, OP_WRITE = 6'd8, OP_JUMP = 6'd9;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_END} st_t;
  typedef enum logic [1:0] {K_OUT, K_IN, K_WAIT} kind_t;

  logic [15:0]       tbl    [TBL];
  logic [STEP_W-1:0] resume [SEQS];
  st_t               st;
  kind_t             kind;
  logic [SEQ_W-1:0]  seq;
  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] addr, sh;
  logic [11:0]       left, nleft;
  logic [2:0]        w;
  logic [7:0]        rxb;
  logic              wr;

  wire [15:0] ent   = tbl[{seq, step}];
  wire [5:0]  code  = ent[15:10];
  wire [7:0]  opd   = ent[7:0];
  wire [2:0]  lw    = (ent[9:8] == 2'd1) ? 3'd2 : (ent[9:8] == 2'd2) ? 3'd4 : 3'd1;
  wire [7:0]  abits = (opd > 8'(ADDR_W)) ? 8'(ADDR_W) : opd;
  wire        known = code inside {OP_CMD, OP_ADDR, OP_DUMMY, OP_MODE, OP_READ, OP_WRITE};
  wire        last  = (step == STEP_W'(STEPS - 1));
  wire        at_byte = (left[2:0] == w);
  wire        fin   = (left <= {9'd0, w});
  wire [7:0]  rx_next = (w == 3'd4) ? {rxb[3:0], io_in} :
                        (w == 3'd2) ? {rxb[5:0], io_in[1:0]} : {rxb[6:0], io_in[1]};
  wire [3:0]  mask  = (w == 3'd4) ? 4'hF : (w == 3'd2) ? 4'h3 : 4'h1;

  always_comb begin
    case (code)
      OP_CMD, OP_MODE:   nleft = 12'd8;
      OP_ADDR:           nleft = {4'd0, abits};
      OP_DUMMY:          nleft = {4'd0, opd} * {9'd0, lw};
      OP_READ, OP_WRITE: nleft = {1'b0, opd, 3'b000};
      default:           nleft = 12'd0;
    endcase
  end

  assign busy   = (st != S_IDLE);
  assign done   = (st == S_END);
  assign cs_n   = !(st == S_LOAD || st == S_SHIFT);
  assign sck_en = (st == S_SHIFT);
  assign io_oe  = (st == S_SHIFT && kind == K_OUT) ? mask : 4'h0;
  assign io_out = io_oe & ((w == 3'd4) ? sh[ADDR_W-1 -: 4] :
                           (w == 3'd2) ? {2'b00, sh[ADDR_W-1 -: 2]} : {3'b000, sh[ADDR_W-1]});
  assign tx_pop = (st == S_LOAD && code == OP_WRITE && opd != 8'd0) ||
                  (st == S_SHIFT && kind == K_OUT && wr && at_byte && !fin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL; i++) tbl[i] <= 16'h0000;
      for (int i = 0; i < SEQS; i++) resume[i] <= '0;
      tbl[0] <= {OP_CMD,  2'd0, 8'h03};
      tbl[1] <= {OP_ADDR, 2'd0, 8'd24};
      tbl[2] <= {OP_READ, 2'd0, 8'd8};
      tbl[3] <= {OP_JUMP, 2'd0, 8'd0};
      st <= S_IDLE; kind <= K_OUT; seq <= '0; step <= '0;
      addr <= '0; sh <= '0; left <= '0; w <= 3'd1; rxb <= '0; wr <= 1'b0;
      rx_data <= '0; rx_push <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      if (tbl_we) tbl[tbl_addr] <= tbl_wdata;
      case (st)
        S_IDLE: if (start) begin
          seq  <= start_seq;
          step <= resume[start_seq];
          addr <= start_addr;
          st   <= S_LOAD;
        end
        S_LOAD: begin
          w    <= lw;
          left <= nleft;
          wr   <= (code == OP_WRITE);
          case (code)
            OP_CMD, OP_MODE: begin sh <= {opd, {(ADDR_W-8){1'b0}}}; kind <= K_OUT; end
            OP_ADDR:         begin sh <= addr << (ADDR_W - int'(abits)); kind <= K_OUT; end
            OP_WRITE:        begin sh <= {tx_data, {(ADDR_W-8){1'b0}}}; kind <= K_OUT; end
            OP_READ:         kind <= K_IN;
            default:         kind <= K_WAIT;
          endcase
          if (code == OP_JUMP) begin
            resume[seq] <= opd[STEP_W-1:0];
            st <= S_END;
          end else if (!known) st <= S_END;
          else if (nleft != 12'd0) st <= S_SHIFT;
          else if (last) st <= S_END;
          else step <= step + 1'b1;
        end
        S_SHIFT: begin
          sh   <= sh << w;
          left <= left - {9'd0, w};
          if (kind == K_IN) begin
            rxb <= rx_next;
            if (at_byte) begin rx_data <= rx_next; rx_push <= 1'b1; end
          end
          if (wr && at_byte && !fin) sh <= {tx_data, {(ADDR_W-8){1'b0}}};
          if (fin) begin
            if (last) st <= S_END;
            else begin step <= step + 1'b1; st <= S_LOAD; end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_quiet_deselect_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sck_en && io_oe == 4'h0));
  assert_done_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
  assert_lane_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0 || io_oe == 4'h1 || io_oe == 4'h3 || io_oe == 4'hF));
  assert_begin_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_push_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> ($past(sck_en) && $past(io_oe) == 4'h0));
  assert_pop_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !cs_n);
endmodule

// File: tb/sflash_seq_bench.sv
`timescale 1ns/1ps
module sflash_seq_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, tbl_we, start;
  logic [6:0] tbl_addr;
  logic [15:0] tbl_wdata;
  logic [3:0] start_seq;
  logic [31:0] start_addr;
  logic [7:0] tx_data, rx_data;
  logic tx_pop, rx_push, cs_n, sck_en, busy, done;
  logic [3:0] io_out, io_oe;
  logic [3:0] io_in = 4'h0;

  sflash_seq u_sflash_seq (.clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .start(start), .start_seq(start_seq), .start_addr(start_addr),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push), .cs_n(cs_n),
    .sck_en(sck_en), .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .busy(busy), .done(done));

  int errors = 0, checks = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int k);
    return 8'(k * 37 + 90);
  endfunction
  function automatic logic [15:0] ent(int c, int p, int o);
    return {6'(c), 2'(p), 8'(o)};
  endfunction

  int ntx = 0;
  always @(posedge clk) if (tx_pop) ntx <= ntx + 1;
  assign tx_data = pat(ntx);

  logic [15:0] mtab [128];
  int mres [16];
  int ecnt, etx, ocnt, orxn;
  logic [3:0] eoe [4096], eout [4096], ooe [4096], oout [4096], oin [4096];
  int ew [4096];
  string ereq [4096];
  logic [7:0] orx [1024];
  bit logging = 0;

  always @(negedge clk) begin
    if (logging && !cs_n && sck_en && ocnt < 4096) begin
      logic [3:0] v;
      v = 4'($urandom);
      io_in = v;
      ooe[ocnt] = io_oe; oout[ocnt] = io_out; oin[ocnt] = v;
      ocnt++;
    end
    if (logging && rx_push && orxn < 1024) begin orx[orxn] = rx_data; orxn++; end
  end

  task automatic epush(logic [3:0] oe, logic [3:0] o, int w, string tag);
    if (ecnt < 4096) begin eoe[ecnt] = oe; eout[ecnt] = o; ew[ecnt] = w; ereq[ecnt] = tag; ecnt++; end
  endtask

  task automatic emit(logic [31:0] val, int nbits, int w, string tag);
    logic [3:0] m, o;
    m = (w == 4) ? 4'hF : (w == 2) ? 4'h3 : 4'h1;
    for (int l = nbits; l > 0; l -= w) begin
      o = (w == 4) ? val[31:28] : (w == 2) ? {2'b00, val[31:30]} : {3'b000, val[31]};
      epush(m, o, 0, tag);
      val = val << w;
    end
  endtask

  task automatic gen(int s, logic [31:0] a, int k);
    int stp, code, p, op, w, nb;
    bit fin;
    stp = mres[s]; ecnt = 0; etx = 0; fin = 0;
    while (!fin) begin
      code = int'(mtab[s*8+stp][15:10]); p = int'(mtab[s*8+stp][9:8]); op = int'(mtab[s*8+stp][7:0]);
      w = (p == 1) ? 2 : (p == 2) ? 4 : 1;
      case (code)
        1, 4: emit({8'(op), 24'h0}, 8, w, "R4");
        2: begin nb = (op > 32) ? 32 : op; if (nb > 0) emit(a << (32 - nb), nb, w, "R5"); end
        3: for (int c = 0; c < op; c++) epush(4'h0, 4'h0, 0, "R6");
        7: for (int c = 0; c < op * 8 / w; c++) epush(4'h0, 4'h0, w, "R7");
        8: for (int b = 0; b < op; b++) begin emit({pat(k), 24'h0}, 8, w, "R8"); k++; etx++; end
        9: begin mres[s] = op & 7; fin = 1; end
        default: fin = 1;
      endcase
      if (!fin) begin stp++; if (stp == 8) fin = 1; end
    end
  endtask

  task automatic put(int s, int i, logic [15:0] v);
    @(negedge clk); tbl_we = 1'b1; tbl_addr = 7'(s*8+i); tbl_wdata = v; mtab[s*8+i] = v;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic run(int s, logic [31:0] a, int intrude);
    int txb, t, bad, erxn, nb;
    logic [7:0] acc, erx [1024];
    txb = ntx;
    gen(s, a, txb);
    ocnt = 0; orxn = 0; logging = 1;
    @(negedge clk); start = 1'b1; start_seq = 4'(s); start_addr = a;
    @(negedge clk); start = 1'b0;
    chk(busy && !cs_n, "R3", "busy/cs after start", {busy, cs_n}, 2'b10);
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk); t++;
      if (intrude >= 0 && t == 3) begin start = 1'b1; start_seq = 4'(intrude); start_addr = ~a; end
      else start = 1'b0;
    end
    start = 1'b0;
    chk(done && cs_n, "R11", "done with cs high", {done, cs_n}, 2'b11);
    @(negedge clk);
    chk(!busy && !done, "R11", "idle after done", {busy, done}, 2'b00);
    logging = 0;
    chk(ocnt == ecnt, "R4", "serial cycle count", ocnt, ecnt);
    bad = -1;
    for (int i = 0; i < ecnt && i < ocnt; i++)
      if (bad < 0 && (ooe[i] !== eoe[i] || oout[i] !== eout[i])) bad = i;
    if (bad >= 0) chk(0, ereq[bad], "lane oe/out", {ooe[bad], oout[bad]}, {eoe[bad], eout[bad]});
    else chk(1, "R4", "lanes", 0, 0);
    erxn = 0; nb = 0; acc = 0;
    for (int i = 0; i < ecnt && i < ocnt; i++) begin
      if (ew[i] == 4) acc = {acc[3:0], oin[i]};
      else if (ew[i] == 2) acc = {acc[5:0], oin[i][1:0]};
      else if (ew[i] == 1) acc = {acc[6:0], oin[i][1]};
      nb += ew[i];
      if (ew[i] > 0 && nb == 8) begin erx[erxn] = acc; erxn++; nb = 0; end
    end
    chk(orxn == erxn, "R7", "rx byte count", orxn, erxn);
    bad = -1;
    for (int i = 0; i < erxn && i < orxn; i++) if (bad < 0 && orx[i] !== erx[i]) bad = i;
    if (bad >= 0) chk(0, "R7", "rx byte", orx[bad], erx[bad]); else chk(1, "R7", "rx", 0, 0);
    chk(ntx - txb == etx, "R8", "tx pops", ntx - txb, etx);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 128; i++) mtab[i] = 16'h0;
    for (int i = 0; i < 16; i++) mres[i] = 0;
    mtab[0] = ent(1, 0, 8'h03); mtab[1] = ent(2, 0, 24); mtab[2] = ent(7, 0, 8); mtab[3] = ent(9, 0, 0);
    rst_n = 1'b0; tbl_we = 1'b0; start = 1'b0; tbl_addr = '0; tbl_wdata = '0; start_seq = '0; start_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && cs_n && !sck_en && io_oe == 0 && !done && !rx_push, "R11", "reset outputs",
        {busy, cs_n, sck_en, done, rx_push}, 5'b01000);

    // R2 default program
    run(0, 32'h00ABCDEF, -1);
    chk(ocnt == 96, "R2", "default cycles", ocnt, 96);
    chk(oout[6] == 1 && oout[7] == 1 && oout[5] == 0, "R2", "command 0x03", {oout[5], oout[6], oout[7]}, 12'h011);
    chk(orxn == 8, "R2", "default byte count", orxn, 8);

    // R9 continuous quad read
    put(2, 0, ent(1, 0, 8'hEB)); put(2, 1, ent(2, 2, 24)); put(2, 2, ent(4, 2, 8'hA5));
    put(2, 3, ent(3, 0, 4)); put(2, 4, ent(7, 2, 4)); put(2, 5, ent(9, 0, 1));
    run(2, 32'h00123456, -1);
    chk(ocnt == 28, "R9", "first run cycles", ocnt, 28);
    run(2, 32'h00654321, -1);
    chk(ocnt == 20, "R9", "restart skips command", ocnt, 20);
    chk(ooe[0] == 4'hF, "R9", "first lane mask", ooe[0], 4'hF);

    // R1 pad 3, dual write
    put(3, 0, ent(1, 3, 8'h32)); put(3, 1, ent(2, 1, 24)); put(3, 2, ent(8, 1, 3)); put(3, 3, ent(9, 0, 0));
    run(3, 32'h00C0FFEE, -1);
    chk(ooe[0] == 4'h1, "R1", "pad field 3 is one lane", ooe[0], 1);
    chk(ooe[20] == 4'h3, "R8", "dual write mask", ooe[20], 3);

    // R10 eight entries without jump, then unknown code
    for (int i = 0; i < 8; i++) put(4, i, ent(1, 2, 8'h11 * (i + 1)));
    run(4, 0, -1);
    chk(ocnt == 16, "R10", "stop after entry 7", ocnt, 16);
    run(4, 0, -1);
    chk(ocnt == 16, "R10", "restart entry unchanged", ocnt, 16);
    put(5, 0, ent(1, 0, 8'h9F)); put(5, 1, ent(6'h3F, 0, 0)); put(5, 2, ent(1, 0, 8'h55));
    run(5, 0, -1);
    chk(ocnt == 8, "R10", "unknown code stops", ocnt, 8);

    // R6 zero operands
    put(6, 0, ent(7, 0, 0)); put(6, 1, ent(3, 2, 0)); put(6, 2, ent(2, 0, 0));
    put(6, 3, ent(1, 1, 8'h9F)); put(6, 4, ent(8, 0, 0)); put(6, 5, ent(9, 0, 0));
    run(6, 32'hFFFFFFFF, -1);
    chk(ocnt == 4, "R6", "zero operands take no cycle", ocnt, 4);

    // R3 start while busy
    run(2, 32'h00777777, 5);
    chk(ocnt == ecnt && ocnt == 20, "R3", "start while busy ignored", ocnt, 20);

    // random programs
    for (int it = 0; it < 40; it++) begin
      int s, n, c, r;
      int codes [6] = '{1, 2, 3, 4, 7, 8};
      int alen [6] = '{0, 8, 16, 24, 32, 40};
      s = 7 + int'($urandom % 9);
      n = 1 + int'($urandom % 8);
      for (int i = 0; i < 8; i++) begin
        if (i >= n) put(s, i, 16'h0);
        else if (i == n - 1 && n < 8 && ($urandom % 3) != 0)
          put(s, i, ent(($urandom % 4 == 0) ? 6'h3F : 9, 0, int'($urandom % 8)));
        else begin
          c = codes[$urandom % 6];
          r = (c == 2) ? alen[$urandom % 6] : (c == 3) ? int'($urandom % 7) :
              (c == 7) ? int'($urandom % 5) : (c == 8) ? int'($urandom % 4) : int'($urandom % 256);
          put(s, i, ent(c, int'($urandom % 4), r));
        end
      end
      run(s, $urandom, -1);
      run(s, $urandom, -1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule